// File: doc/BRIEF.md
# Vector lane insert-and-zero unit

This unit takes a 128-bit first-source vector made of four 32-bit lanes and places one 32-bit scalar into one of those lanes. It then clears any lanes picked by a per-lane mask and fills the destination bits above 128 according to the encoding mode. The scalar comes from one lane of a second-source vector, or from a 32-bit memory word. An 8-bit control byte chooses the source lane, the destination lane and the zero mask. The result is always presented at the full destination width, which is a parameter.

Operands enter on a valid/ready stream. A transfer takes place on a rising edge where `in_valid` and `in_ready` are both high. The result comes out one cycle later on a second valid/ready stream. While `out_valid` is high and `out_ready` is low, the output register holds its value and `in_ready` stays low, so back-pressure flows straight through. The extended encoding with the vector-length bit set is an illegal form. It produces a fault beat, and that beat does not update the result register.

Top module: `vec_insert_unit`

## Requirements
- R1: With a register source (`src_is_mem`=0), the scalar is lane `ctrl[7:6]` of `src2_vec`, where lane i occupies bits [32i+31:32i].
- R2: With a memory source (`src_is_mem`=1), the scalar is `mem_word`, and `ctrl[7:6]` has no effect on the result.
- R3: The scalar replaces lane `ctrl[5:4]` of `src1_vec`. The other three lanes pass through from `src1_vec` unchanged.
- R4: Zeroing happens after the insert. If `ctrl[i]` is 1 (i = 0..3), result lane i becomes 0x00000000, and this includes the lane just written.
- R5: In legacy mode (`ext_mode`=0), result bits [MAX_W-1:128] equal `dest_upper_old`. `vlen_bit` is ignored and never causes a fault.
- R6: In extended mode (`ext_mode`=1) with `vlen_bit`=0, result bits [MAX_W-1:128] are zero.
- R7: In extended mode with `vlen_bit`=1, the output beat carries `out_fault`=1, and `out_result` keeps its previous value. `out_fault` is high only while `out_valid` is high.
- R8: An input accepted at a rising edge appears on `out_valid`/`out_result` right after that edge. Results leave in the order they were accepted.
- R9: `in_ready` is high exactly when the output register is empty or is being drained. While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_result` and `out_fault` hold their values.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_fault` and `out_result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat is valid |
| in_ready | output | 1 | Unit can take an operand beat |
| src1_vec | input | 128 | First source, the base vector |
| src2_vec | input | 128 | Second source vector (register form) |
| mem_word | input | 32 | Scalar word (memory form) |
| src_is_mem | input | 1 | 1: scalar from `mem_word`; 0: scalar from `src2_vec` |
| ctrl | input | 8 | [7:6] source lane, [5:4] destination lane, [3:0] zero mask |
| ext_mode | input | 1 | 0: legacy form; 1: extended form |
| vlen_bit | input | 1 | Vector-length bit; illegal when 1 in extended form |
| dest_upper_old | input | MAX_W-128 | Old destination bits above 128, kept in legacy form |
| out_valid | output | 1 | Result beat is valid |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | MAX_W | Destination value |
| out_fault | output | 1 | Undefined-instruction fault for this beat |

## Verification
Each result, whether a value or a fault beat, is due in the cycle right after its input is accepted. When the consumer stalls, the result is due later, at the first cycle in which `out_ready` is high. The bench drives inputs and `out_ready` away from the rising edge. A scoreboard queue holds the expected beats and is popped only at a falling edge where `out_valid` and `out_ready` are both high, so each comparison lines up with the transfer. A direct latency check runs while the consumer never stalls: one cycle after acceptance, `out_valid` must already be high. A stall check confirms that a held beat is unchanged at the following falling edge.

// File: rtl/vins_pkg.sv
package vins_pkg;
  localparam int LANE_W    = 32;
  localparam int NUM_LANES = 4;
  localparam int VEC_W     = LANE_W * NUM_LANES;
  localparam int IDX_W     = $clog2(NUM_LANES);
  localparam int CTRL_W    = 2 * IDX_W + NUM_LANES;

  // Field order is behavioural: source lane on top, then destination lane, then mask.
  typedef struct packed {
    logic [IDX_W-1:0]     src_lane;
    logic [IDX_W-1:0]     dst_lane;
    logic [NUM_LANES-1:0] zmask;
  } ctrl_t;
endpackage

// File: rtl/vins_lane_pick.sv
module vins_lane_pick #(
  parameter int LANE_W    = vins_pkg::LANE_W,
  parameter int NUM_LANES = vins_pkg::NUM_LANES,
  localparam int VEC_W    = LANE_W * NUM_LANES,
  localparam int IDX_W    = $clog2(NUM_LANES)
) (
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [LANE_W-1:0] mem_word,
  input  logic              src_is_mem,
  input  logic [IDX_W-1:0]  sel,
  output logic [LANE_W-1:0] scalar
);
  logic [LANE_W-1:0] lanes [NUM_LANES];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_unpack
    assign lanes[i] = src_vec[i*LANE_W +: LANE_W];
  end

  // The memory form ignores the lane select entirely.
  always_comb begin
    if (src_is_mem) scalar = mem_word;
    else            scalar = lanes[sel];
  end
endmodule

// File: rtl/vins_merge_zero.sv
module vins_merge_zero #(
  parameter int LANE_W    = vins_pkg::LANE_W,
  parameter int NUM_LANES = vins_pkg::NUM_LANES,
  localparam int VEC_W    = LANE_W * NUM_LANES,
  localparam int IDX_W    = $clog2(NUM_LANES)
) (
  input  logic [VEC_W-1:0]     base_vec,
  input  logic [LANE_W-1:0]    scalar,
  input  logic [IDX_W-1:0]     dst_sel,
  input  logic [NUM_LANES-1:0] zmask,
  output logic [VEC_W-1:0]     merged
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [LANE_W-1:0] inserted;
    assign inserted = (dst_sel == IDX_W'(i)) ? scalar : base_vec[i*LANE_W +: LANE_W];
    // Mask is applied after insertion, so it wins over the written lane.
    assign merged[i*LANE_W +: LANE_W] = zmask[i] ? '0 : inserted;
  end
endmodule

// File: rtl/vins_upper_fill.sv
module vins_upper_fill #(
  parameter int UP_W = 384
) (
  input  logic            ext_mode,
  input  logic [UP_W-1:0] upper_old,
  output logic [UP_W-1:0] upper_out
);
  assign upper_out = ext_mode ? '0 : upper_old;
endmodule

// File: rtl/vec_insert_unit.sv
module vec_insert_unit #(
  parameter int LANE_W    = vins_pkg::LANE_W,
  parameter int NUM_LANES = vins_pkg::NUM_LANES,
  parameter int MAX_W     = 512,
  localparam int VEC_W    = LANE_W * NUM_LANES,
  localparam int UP_W     = MAX_W - VEC_W,
  localparam int IDX_W    = $clog2(NUM_LANES),
  localparam int CTRL_W   = 2 * IDX_W + NUM_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VEC_W-1:0]  src1_vec,
  input  logic [VEC_W-1:0]  src2_vec,
  input  logic [LANE_W-1:0] mem_word,
  input  logic              src_is_mem,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              ext_mode,
  input  logic              vlen_bit,
  input  logic [UP_W-1:0]   dest_upper_old,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MAX_W-1:0]  out_result,
  output logic              out_fault
);
  logic [IDX_W-1:0]     src_lane;
  logic [IDX_W-1:0]     dst_lane;
  logic [NUM_LANES-1:0] zmask;
  logic [LANE_W-1:0]    scalar;
  logic [VEC_W-1:0]     merged;
  logic [UP_W-1:0]      upper;
  logic                 accept;
  logic                 fault_now;

  assign src_lane = ctrl[CTRL_W-1 -: IDX_W];
  assign dst_lane = ctrl[NUM_LANES +: IDX_W];
  assign zmask    = ctrl[NUM_LANES-1:0];

  vins_lane_pick #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_pick (
    .src_vec(src2_vec), .mem_word(mem_word), .src_is_mem(src_is_mem),
    .sel(src_lane), .scalar(scalar)
  );

  vins_merge_zero #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_merge (
    .base_vec(src1_vec), .scalar(scalar), .dst_sel(dst_lane),
    .zmask(zmask), .merged(merged)
  );

  vins_upper_fill #(.UP_W(UP_W)) u_upper (
    .ext_mode(ext_mode), .upper_old(dest_upper_old), .upper_out(upper)
  );

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign fault_now = ext_mode && vlen_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_fault  <= 1'b0;
      out_result <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_fault <= fault_now;
      if (!fault_now) out_result <= {upper, merged};
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
    end
  end

  assert_fault_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> out_valid) else $error("fault without valid");

  assert_fault_keeps_result_R7: assert property (@(posedge clk) disable iff (rst)
    accept && fault_now |=> out_fault && $stable(out_result)) else $error("fault wrote result");

  assert_accept_latency_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid) else $error("result not registered next cycle");

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_fault))
    else $error("output changed while stalled");

  assert_legacy_upper_R5: assert property (@(posedge clk) disable iff (rst)
    accept && !ext_mode |=> !out_fault && out_result[MAX_W-1:VEC_W] == $past(dest_upper_old))
    else $error("legacy upper bits not kept");

  assert_ext_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    accept && ext_mode && !vlen_bit |=> !out_fault && out_result[MAX_W-1:VEC_W] == '0)
    else $error("extended upper bits not cleared");

  assert_full_mask_R4: assert property (@(posedge clk) disable iff (rst)
    accept && !fault_now && zmask == '1 |=> out_result[VEC_W-1:0] == '0)
    else $error("full mask left data");
endmodule

// File: tb/vec_insert_unit_tb.sv
module vec_insert_unit_tb;
  localparam int MAX_W = 512;
  localparam int UP_W  = MAX_W - 128;

  typedef struct {
    logic [MAX_W-1:0] res;
    logic             flt;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [127:0] src1_vec = '0, src2_vec = '0;
  logic [31:0] mem_word = '0;
  logic src_is_mem = 1'b0, ext_mode = 1'b0, vlen_bit = 1'b0;
  logic [7:0] ctrl = '0;
  logic [UP_W-1:0] dest_upper_old = '0;
  logic out_valid, out_ready = 1'b1, out_fault;
  logic [MAX_W-1:0] out_result;

  int n_checks = 0, n_fail = 0;
  bit stall_en = 1'b0;
  exp_t sb[$];
  logic [MAX_W-1:0] model_last = '0;

  always #4 clk = ~clk;

  vec_insert_unit #(.MAX_W(MAX_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src1_vec(src1_vec), .src2_vec(src2_vec), .mem_word(mem_word),
    .src_is_mem(src_is_mem), .ctrl(ctrl), .ext_mode(ext_mode), .vlen_bit(vlen_bit),
    .dest_upper_old(dest_upper_old), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_fault(out_fault)
  );

  function automatic logic [MAX_W-1:0] ref_model(
    input logic [127:0] a, input logic [127:0] b, input logic [31:0] m,
    input logic is_mem, input logic [7:0] c, input logic ext, input logic [UP_W-1:0] up);
    logic [31:0] s;
    logic [127:0] low;
    s = is_mem ? m : b[c[7:6]*32 +: 32];
    low = a;
    low[c[5:4]*32 +: 32] = s;
    for (int i = 0; i < 4; i++) if (c[i]) low[i*32 +: 32] = 32'h0;
    return {(ext ? {UP_W{1'b0}} : up), low};
  endfunction

  function automatic void chk(input bit ok, input string tag, input logic [MAX_W-1:0] act,
                             input logic [MAX_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // Driver: called at a falling edge; pushes the expected beat when it offers the input.
  task automatic drive(input logic [127:0] a, input logic [127:0] b, input logic [31:0] m,
                       input logic is_mem, input logic [7:0] c, input logic ext,
                       input logic vl, input logic [UP_W-1:0] up, input string tag);
    exp_t e;
    while (!in_ready) @(negedge clk);
    src1_vec = a; src2_vec = b; mem_word = m; src_is_mem = is_mem; ctrl = c;
    ext_mode = ext; vlen_bit = vl; dest_upper_old = up; in_valid = 1'b1;
    e.tag = tag;
    if (ext && vl) begin
      e.flt = 1'b1; e.res = model_last;
    end else begin
      e.flt = 1'b0; e.res = ref_model(a, b, m, is_mem, c, ext, up); model_last = e.res;
    end
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    if (!stall_en) chk(out_valid === 1'b1, "R8 latency", {511'b0, out_valid}, 1);
  endtask

  // Consumer ready changes just after the rising edge.
  always @(posedge clk) begin
    #1;
    out_ready <= stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // Monitor
  bit held = 1'b0;
  logic [MAX_W-1:0] held_res;
  logic held_flt;
  always @(negedge clk) begin
    if (!rst) begin
      if (held) chk(out_valid === 1'b1 && out_result === held_res && out_fault === held_flt,
                    "R9 stall hold", out_result, held_res);
      if (out_valid && out_ready) begin
        if (sb.size() == 0) chk(1'b0, "R8 unexpected beat", out_result, '0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(out_result === e.res, e.tag, out_result, e.res);
          chk(out_fault === e.flt, {e.tag, " fault R7"}, {511'b0, out_fault}, {511'b0, e.flt});
        end
      end
      held = out_valid && !out_ready;
      held_res = out_result;
      held_flt = out_fault;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  localparam logic [127:0] A = 128'h44444444_33333333_22222222_11111111;
  localparam logic [127:0] B = 128'hdddddddd_cccccccc_bbbbbbbb_aaaaaaaa;
  localparam logic [UP_W-1:0] UPV = {12{32'h5a5a_c3c3}};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_fault === 1'b0 && out_result === '0, "R10 reset",
        out_result, '0);
    chk(in_ready === 1'b1, "R9 ready when empty", {511'b0, in_ready}, 1);

    drive(A, B, 32'h0, 1'b0, 8'b10_01_0000, 1'b0, 1'b0, UPV, "R1 R3 R5 src2->dst1");
    for (int s = 0; s < 4; s++)
      drive(A, B, 32'h0, 1'b0, {2'(s), 2'(3 - s), 4'b0}, 1'b0, 1'b0, UPV, "R1 lane sweep");
    drive(A, B, 32'hfeedbeef, 1'b1, 8'b11_10_0000, 1'b0, 1'b0, UPV, "R2 mem ignores src sel");
    drive(A, B, 32'hfeedbeef, 1'b1, 8'b00_10_0000, 1'b0, 1'b0, UPV, "R2 mem sel0");
    drive(A, B, 32'h0, 1'b0, 8'b01_10_0100, 1'b0, 1'b0, UPV, "R4 zero written lane");
    drive(A, B, 32'h0, 1'b0, 8'b01_10_1001, 1'b0, 1'b0, UPV, "R4 zero other lanes");
    drive(A, B, 32'h0, 1'b0, 8'b11_00_1111, 1'b0, 1'b0, UPV, "R4 full mask");
    drive(A, B, 32'h0, 1'b0, 8'b11_00_0000, 1'b1, 1'b0, UPV, "R6 ext upper clear");
    drive(A, B, 32'h0, 1'b0, 8'b00_11_0010, 1'b1, 1'b1, UPV, "R7 ext fault");
    drive(B, A, 32'h0, 1'b0, 8'b00_11_0000, 1'b1, 1'b1, UPV, "R7 fault back to back");
    drive(B, A, 32'h0, 1'b0, 8'b00_11_0000, 1'b0, 1'b1, UPV, "R5 legacy ignores vlen");

    stall_en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 200; k++) begin
      drive({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
            $urandom, 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
            {12{$urandom}}, "R8 R9 random stream");
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    stall_en = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule